// File: doc/BRIEF.md
# Shift-Immediate Move Executor

This block carries out one family of 16-bit compact instructions: it takes a copy of one of eight 32-bit low registers, shifts it by a constant held in the instruction word, stores the result in a low register and updates the N/Z/C/V condition flags from that result. Three shift kinds exist: logical left, logical right and arithmetic right. Each accepted instruction completes in one clock. The result and the new flags are visible from the following edge.

Instruction words arrive on a valid/ready stream. `ins_ready` is high in every cycle in which `rst` is low, so the block never applies back-pressure. A word is consumed on each rising edge where both `ins_valid` and `ins_ready` are high. While `rst` is high the stream stalls and no word is taken. A producer may hold `ins_valid` high on consecutive cycles to issue one instruction per cycle.

A word outside this family is consumed and flagged as unsupported, and it has no effect on architectural state. A debug port reads any register and the flags combinationally. A preload port lets a test environment place values in the registers.

Top module: `shimm_exec`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers, the flags and `unsupported`. `ins_ready` is low while `rst` is high.
- R2: A word belongs to the family when bits [15:13] are 000 and bits [12:11] are not 11. In such a word, bits [12:11] give the shift kind, bits [10:6] the amount, bits [5:3] the source register and bits [2:0] the destination register. The result is readable on the debug port after the accepting edge. Source and destination may be the same register, in which case the old value is shifted.
- R3: Kind 00 (logical left) with amount k in 1..31 writes src<<k and sets C to source bit 32-k. With amount 0 it writes the source unchanged and leaves C unchanged.
- R4: Kind 01 (logical right) with k in 1..31 writes src>>k and sets C to source bit k-1. Amount 0 acts as a shift by 32: the result is 0 and C is set to source bit 31.
- R5: Kind 10 (arithmetic right) with k in 1..31 writes the sign-filled src>>k and sets C to source bit k-1. Amount 0 acts as a shift by 32: every result bit and C equal source bit 31.
- R6: `dbg_flags` is {N,Z,C,V} at bits [3:0]. Each in-family instruction sets N to result bit 31 and sets Z to 1 exactly when the result is zero. V is never altered by an instruction.
- R7: An accepted word outside the family (prefix other than 000, or prefix 000 with kind 11) drives `unsupported` high in the following cycle. It leaves every register and the flags unchanged.
- R8: When `ins_valid` is low, no register or flag changes through the instruction path, and `unsupported` is low in the following cycle.
- R9: With `pre_en` high and `ins_valid` low, a rising edge writes `pre_data` into register `pre_idx`. With `ins_valid` high, the preload is ignored.
- R10: `dbg_data` shows register `dbg_idx` and `dbg_flags` shows the flags, both combinationally with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Block can take a word (high whenever out of reset) |
| ins_word | input | 16 | Instruction word |
| unsupported | output | 1 | Previous accepted word was outside the family |
| pre_en | input | 1 | Preload write enable |
| pre_idx | input | 3 | Preload register index |
| pre_data | input | 32 | Preload value |
| dbg_idx | input | 3 | Debug read register index |
| dbg_data | output | 32 | Debug read value |
| dbg_flags | output | 4 | Flags {N,Z,C,V} |

## Verification
The hardest state to reach from the ports is the case where an instruction must leave C untouched, which happens with a left shift by zero. That check means something only when C already holds a 1 that an earlier instruction left there. The bench therefore first runs a left shift whose ejected bit is 1, and then issues the zero-amount left shift and checks that C is still set. The amount-zero right shifts are paired with sources whose bit 31 differs, so that the shift-by-32 carry and fill can be told apart from a no-op. The case where preload and instruction happen together is driven in one cycle, so the ignored write can be seen by reading the untouched register.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
  localparam int IW = 16;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_BAD = 2'b11
  } sh_kind_e;

  typedef struct packed {
    logic       legal;
    sh_kind_e   kind;
    logic [4:0] amt;
    logic [2:0] src;
    logic [2:0] dst;
  } shimm_dec_t;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
  import shimm_pkg::*;
(
  input  logic [IW-1:0] word,
  output shimm_dec_t    dec
);
  always_comb begin
    dec.kind  = sh_kind_e'(word[12:11]);
    dec.amt   = word[10:6];
    dec.src   = word[5:3];
    dec.dst   = word[2:0];
    dec.legal = (word[15:13] == 3'b000) && (word[12:11] != 2'b11);
  end
endmodule

// File: rtl/shimm_shifter.sv
module shimm_shifter
  import shimm_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  sh_kind_e      kind,
  input  logic [SW-1:0] amt,
  input  logic [W-1:0]  src,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  logic [W:0]        lext;
  logic [W:0]        rext;
  logic signed [W:0] aext;
  logic              zamt;
  logic              sgn;

  always_comb begin
    lext = {1'b0, src} << amt;
    rext = {src, 1'b0} >> amt;
    aext = $signed({src, 1'b0}) >>> amt;
    zamt = (amt == '0);
    sgn  = src[W-1];
    case (kind)
      SH_LSL: begin
        res  = zamt ? src : lext[W-1:0];
        cout = zamt ? cin : lext[W];
      end
      SH_LSR: begin
        res  = zamt ? '0 : rext[W:1];
        cout = zamt ? sgn : rext[0];
      end
      SH_ASR: begin
        res  = zamt ? {W{sgn}} : aext[W:1];
        cout = zamt ? sgn : aext[0];
      end
      default: begin
        res  = src;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/shimm_regfile.sv
module shimm_regfile #(
  parameter int W  = 32,
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ridx,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] didx,
  output logic [W-1:0]  ddata
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && (widx == AW'(g))) regs[g] <= wdata;
    end
  end

  assign rdata = regs[ridx];
  assign ddata = regs[didx];
endmodule

// File: rtl/shimm_exec.sv
module shimm_exec
  import shimm_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = 8,
  parameter int AW = $clog2(N),
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [IW-1:0] ins_word,
  output logic          unsupported,
  input  logic          pre_en,
  input  logic [AW-1:0] pre_idx,
  input  logic [W-1:0]  pre_data,
  input  logic [AW-1:0] dbg_idx,
  output logic [W-1:0]  dbg_data,
  output logic [3:0]    dbg_flags
);
  shimm_dec_t    dec;
  logic          accept;
  logic          exe_we;
  logic          pre_we;
  logic          rf_we;
  logic [AW-1:0] rf_widx;
  logic [W-1:0]  rf_wdata;
  logic [W-1:0]  src_val;
  logic [W-1:0]  sh_res;
  logic          sh_c;
  logic [3:0]    flag_q;
  logic          unsup_q;

  assign ins_ready = !rst;
  assign accept    = ins_valid && ins_ready;
  assign exe_we    = accept && dec.legal;
  assign pre_we    = pre_en && !ins_valid && !rst;
  assign rf_we     = exe_we || pre_we;
  assign rf_widx   = exe_we ? AW'(dec.dst) : pre_idx;
  assign rf_wdata  = exe_we ? sh_res : pre_data;

  shimm_decode u_dec (
    .word (ins_word),
    .dec  (dec)
  );

  shimm_regfile #(.W(W), .N(N)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .widx  (rf_widx),
    .wdata (rf_wdata),
    .ridx  (AW'(dec.src)),
    .rdata (src_val),
    .didx  (dbg_idx),
    .ddata (dbg_data)
  );

  shimm_shifter #(.W(W)) u_sh (
    .kind (dec.kind),
    .amt  (SW'(dec.amt)),
    .src  (src_val),
    .cin  (flag_q[FL_C]),
    .res  (sh_res),
    .cout (sh_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      unsup_q <= 1'b0;
    end else begin
      unsup_q <= accept && !dec.legal;
      if (exe_we) begin
        flag_q[FL_N] <= sh_res[W-1];
        flag_q[FL_Z] <= (sh_res == '0);
        flag_q[FL_C] <= sh_c;
      end
    end
  end

  assign unsupported = unsup_q;
  assign dbg_flags   = flag_q;
endmodule

// File: rtl/shimm_exec_chk.sv
module shimm_exec_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         ins_valid,
  input logic         ins_ready,
  input logic [15:0]  ins_word,
  input logic         unsupported,
  input logic [3:0]   flags,
  input logic         wr_en,
  input logic [W-1:0] wr_data
);
  logic acc;
  logic bad;
  assign acc = ins_valid && ins_ready;
  assign bad = (ins_word[15:13] != 3'b000) || (ins_word[12:11] == 2'b11);

  p_bad_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && bad) |=> (unsupported && $stable(flags)));

  p_bad_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && bad) |-> !wr_en);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> (!unsupported && $stable(flags)));

  p_neg_flag_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags[3] == $past(wr_data[W-1])));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags[2] == ($past(wr_data) == '0)));

  p_v_keep_r6: assert property (@(posedge clk) disable iff (rst)
    acc |=> $stable(flags[0]));
endmodule

bind shimm_exec shimm_exec_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .ins_word    (ins_word),
  .unsupported (unsupported),
  .flags       (flag_q),
  .wr_en       (exe_we),
  .wr_data     (sh_res)
);

// File: tb/shimm_exec_tb.sv
`timescale 1ns/1ps
module shimm_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ins_valid;
  logic        ins_ready;
  logic [15:0] ins_word;
  logic        unsupported;
  logic        pre_en;
  logic [2:0]  pre_idx;
  logic [31:0] pre_data;
  logic [2:0]  dbg_idx;
  logic [31:0] dbg_data;
  logic [3:0]  dbg_flags;

  int nvec = 0;
  int nerr = 0;
  logic [31:0] m_reg [8];
  logic [3:0]  m_fl;

  always #2.5 clk = ~clk;

  shimm_exec dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .unsupported(unsupported), .pre_en(pre_en),
    .pre_idx(pre_idx), .pre_data(pre_data), .dbg_idx(dbg_idx),
    .dbg_data(dbg_data), .dbg_flags(dbg_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every register and the flags against the bench model.
  task automatic chk_state(input string req);
    for (int i = 0; i < 8; i++) begin
      dbg_idx = 3'(i);
      #0.2;
      chk(req, dbg_data, m_reg[i]);
    end
    chk(req, {28'd0, dbg_flags}, {28'd0, m_fl});
  endtask

  // Expected result from the requirement text (R3, R4, R5, R6).
  task automatic model(input logic [1:0] op, input logic [4:0] k, input logic [2:0] s,
                       input logic [2:0] d);
    logic [31:0] src;
    logic [31:0] res;
    logic        c;
    int          amt;
    src = m_reg[s];
    c   = m_fl[1];
    amt = (k == 0) ? 32 : int'(k);
    if (op == 2'b00) begin
      if (k == 0) res = src;
      else begin res = src << k; c = src[32-amt]; end
    end else begin
      for (int i = 0; i < 32; i++)
        res[i] = (i + amt > 31) ? ((op == 2'b10) ? src[31] : 1'b0) : src[i+amt];
      c = src[amt-1];
    end
    m_reg[d] = res;
    m_fl = {res[31], res == 32'd0, c, m_fl[0]};
  endtask

  task automatic preload(input logic [2:0] i, input logic [31:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = i; pre_data = v;
    @(negedge clk);
    pre_en = 1'b0;
    m_reg[i] = v;
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = w;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic [4:0] k,
                     input logic [2:0] s, input logic [2:0] d);
    issue({3'b000, op, k, s, d});
    model(op, k, s, d);
    chk_state(req);
    chk(req, {31'd0, unsupported}, 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) m_reg[i] = 32'd0;
    m_fl = 4'd0;
    chk("R1 ready low in reset", {31'd0, ins_ready}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    chk_state("R1 reset state");
    chk("R1 unsupported", {31'd0, unsupported}, 32'd0);
    chk("R8 ready high", {31'd0, ins_ready}, 32'd1);
  endtask

  task automatic t_lsl;
    preload(3'd1, 32'h8000_0001);
    run("R3 lsl 1 carry out", 2'b00, 5'd1, 3'd1, 3'd0);
    run("R3 lsl 0 keeps C", 2'b00, 5'd0, 3'd1, 3'd3);
    run("R3 lsl 31", 2'b00, 5'd31, 3'd1, 3'd4);
  endtask

  task automatic t_lsr;
    preload(3'd5, 32'hF400_0000);
    run("R4 lsr 27 R5 to R2", 2'b01, 5'd27, 3'd5, 3'd2);
    chk("R4 lsr 27 value", m_reg[2], 32'h0000_001E);
    run("R4 lsr 0 as 32", 2'b01, 5'd0, 3'd5, 3'd6);
    run("R4 lsr 1", 2'b01, 5'd1, 3'd1, 3'd6);
  endtask

  task automatic t_asr;
    preload(3'd7, 32'h8000_00F8);
    run("R5 asr 4", 2'b10, 5'd4, 3'd7, 3'd6);
    run("R5 asr 0 negative", 2'b10, 5'd0, 3'd7, 3'd0);
    preload(3'd3, 32'h7FFF_FFFF);
    run("R5 asr 0 positive", 2'b10, 5'd0, 3'd3, 3'd4);
    run("R5 asr 31 positive", 2'b10, 5'd31, 3'd3, 3'd4);
  endtask

  task automatic t_same;
    preload(3'd2, 32'h0123_4567);
    run("R2 src equals dst", 2'b00, 5'd4, 3'd2, 3'd2);
    chk("R2 same reg value", m_reg[2], 32'h1234_5670);
  endtask

  task automatic t_unsup;
    issue({3'b000, 2'b11, 5'd3, 3'd1, 3'd0});
    chk("R7 kind 11 flagged", {31'd0, unsupported}, 32'd1);
    chk_state("R7 kind 11 no change");
    issue({3'b001, 2'b00, 5'd3, 3'd1, 3'd0});
    chk("R7 prefix 001 flagged", {31'd0, unsupported}, 32'd1);
    chk_state("R7 prefix no change");
  endtask

  task automatic t_idle;
    @(negedge clk);
    ins_word = {3'b000, 2'b01, 5'd1, 3'd7, 3'd7};
    @(negedge clk);
    chk("R8 idle unsupported low", {31'd0, unsupported}, 32'd0);
    chk_state("R8 idle no change");
  endtask

  task automatic t_preload_blocked;
    @(negedge clk);
    ins_valid = 1'b1; ins_word = {3'b000, 2'b00, 5'd2, 3'd1, 3'd0};
    pre_en = 1'b1; pre_idx = 3'd5; pre_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ins_valid = 1'b0; pre_en = 1'b0;
    model(2'b00, 5'd2, 3'd1, 3'd0);
    chk_state("R9 preload ignored while valid");
    preload(3'd5, 32'hCAFE_0000);
    chk_state("R9 preload writes");
  endtask

  task automatic t_dbg;
    dbg_idx = 3'd5;
    #0.2;
    chk("R10 debug read", dbg_data, 32'hCAFE_0000);
    dbg_idx = 3'd0;
    #0.2;
    chk("R10 debug switch", dbg_data, m_reg[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; ins_valid = 1'b0; ins_word = 16'd0;
    pre_en = 1'b0; pre_idx = 3'd0; pre_data = 32'd0; dbg_idx = 3'd0;
    repeat (3) @(posedge clk);
    t_reset();
    t_lsl();
    t_lsr();
    t_asr();
    t_same();
    t_unsup();
    t_idle();
    t_preload_blocked();
    t_dbg();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule